// File: doc/BRIEF.md
# Transmit Packet FIFO with Length Queue

This block sits between a host write port and a byte-wide frame transmitter. The host writes the bytes of a frame as 32-bit words into a data FIFO. It then writes one command into a separate command FIFO. The command carries the frame's byte count and the byte lane where the first valid byte sits. A frame is released for transmission only when its command arrives. A drain engine takes each command in turn and pulls the data words that the frame spans. It skips the leading pad lanes and sends exactly the stated number of bytes on a valid/ready byte stream, marking the first and last byte.

Before writing a frame, the host reads the data-FIFO word count and compares it against the FIFO depth. Three sticky interrupt sources report conditions to the host: fill level below a programmable threshold, data FIFO full, and command dropped. An enable mask combines these sources into a single interrupt line. Reading the sources clears them. A flush input empties both FIFOs and aborts any frame that is in flight.

Top module: `tx_pkt_fifo`

## Requirements
- R1: After reset, `tx_valid_o` is 0, `wcnt_o` is 0, `irq_src_o` is 0 and `irq_o` is 0.
- R2: `wcnt_o` goes up by one for each word accepted on the data push port and down by one for each word the drain consumes. It never exceeds DATA_DEPTH.
- R3: The command field `cmd_i[15:0]` is the frame length in bytes and `cmd_i[17:16]` is the lane of the first valid byte in the first word. The frame sends exactly length bytes starting at that lane. `tx_sof_o` is high only on the first byte and `tx_eof_o` only on the last.
- R4: Lane k of a word is bits [8k+7:8k], and lanes are sent in ascending order. A frame consumes floor((length + lane + 3) / 4) data words, so `wcnt_o` falls by that amount once the frame has been sent.
- R5: Data words with no command behind them produce no output.
- R6: While `tx_valid_o` is high and `tx_ready_i` is low, the byte, `tx_sof_o` and `tx_eof_o` hold steady until the byte is accepted.
- R7: Source bit 0 (almost empty) is set in every cycle in which `wcnt_o` is below `ae_thresh_i`.
- R8: Source bit 1 (full) is set while `wcnt_o` equals DATA_DEPTH. A word pushed while the FIFO is full is dropped and leaves `wcnt_o` unchanged.
- R9: A command pushed while the command FIFO holds CMD_DEPTH entries is dropped and sets source bit 2 (discard). The frames after it are unaffected.
- R10: While `flush_i` is high, both FIFOs are emptied, any frame in flight is abandoned, and pushes are ignored. On the next cycle `wcnt_o` is 0 and `tx_valid_o` is 0.
- R11: A pulse on `src_rd_i` clears all source bits on the next edge unless a condition sets them again in that same cycle. `irq_o` is high exactly when a source bit and its bit in `irq_en_i` are both set.
- R12: A zero-length command sends no bytes. It consumes one data word if its lane is non-zero and none if its lane is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty both FIFOs and abort the current frame |
| data_push_i | input | 1 | Push one data word |
| data_word_i | input | 32 | Data word; lane 0 in bits [7:0] |
| cmd_push_i | input | 1 | Push one frame command |
| cmd_i | input | 18 | {lane[1:0], length[15:0]} |
| wcnt_o | output | $clog2(DATA_DEPTH+1) | Words held in the data FIFO |
| ae_thresh_i | input | $clog2(DATA_DEPTH+1) | Almost-empty threshold |
| irq_en_i | input | 3 | Source enable mask |
| src_rd_i | input | 1 | Read strobe; clears the sources |
| irq_src_o | output | 3 | Sticky sources {discard, full, almost empty} |
| irq_o | output | 1 | Masked interrupt |
| tx_valid_o | output | 1 | Byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_sof_o | output | 1 | First byte of a frame |
| tx_eof_o | output | 1 | Last byte of a frame |
| tx_ready_i | input | 1 | Downstream accepts the byte |

## Verification
The bench builds the block with DATA_DEPTH=16 and CMD_DEPTH=4. At these sizes a few cycles of pushing fill the data FIFO, and five commands against a stalled drain overflow the command queue, so the full and discard paths are easy to reach. Random frames of up to 60 bytes, with random lanes and random backpressure, still fit in the 16-word FIFO. They cover every lane/length combination at both word boundaries. Directed cases add back-to-back frames, zero-length commands, flush during a stalled frame, and the threshold crossing.

// File: rtl/tx_pkt_pkg.sv
package tx_pkt_pkg;
  localparam int WORD_W   = 32;
  localparam int LANES    = WORD_W / 8;
  localparam int LANE_W   = $clog2(LANES);
  localparam int LEN_W    = 16;
  localparam int CMD_W    = LEN_W + LANE_W;
  localparam int SRC_N    = 3;
  localparam int SRC_AE   = 0;
  localparam int SRC_FULL = 1;
  localparam int SRC_DISC = 2;

  typedef struct packed {
    logic [LANE_W-1:0] lane;
    logic [LEN_W-1:0]  len;
  } tx_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_SKIP = 2'd2
  } drain_st_e;
endpackage

// File: rtl/tx_sfifo.sv
module tx_sfifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign count_o = cnt;
  assign data_o  = mem[rd_ptr];
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tx_drain.sv
module tx_drain
  import tx_pkt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              cmd_empty_i,
  input  tx_cmd_t           cmd_i,
  output logic              cmd_pop_o,
  input  logic              dat_empty_i,
  input  logic [WORD_W-1:0] dat_i,
  output logic              dat_pop_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o,
  input  logic              tx_ready_i
);
  drain_st_e         st_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LANE_W-1:0] lane_q;
  logic              first_q;
  logic              hs, last_byte, last_lane;
  logic [7:0]        lane_byte [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = dat_i[g*8 +: 8];
  end

  assign tx_valid_o = (st_q == ST_SEND) && !dat_empty_i;
  assign tx_data_o  = lane_byte[lane_q];
  assign last_byte  = (rem_q == LEN_W'(1));
  assign last_lane  = (lane_q == LANE_W'(LANES - 1));
  assign tx_sof_o   = tx_valid_o && first_q;
  assign tx_eof_o   = tx_valid_o && last_byte;
  assign hs         = tx_valid_o && tx_ready_i;
  assign cmd_pop_o  = (st_q == ST_IDLE) && !cmd_empty_i && !flush_i;
  assign dat_pop_o  = (hs && (last_lane || last_byte)) ||
                      ((st_q == ST_SKIP) && !dat_empty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      lane_q  <= '0;
      first_q <= 1'b0;
    end else if (flush_i) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (cmd_pop_o) begin
          rem_q   <= cmd_i.len;
          lane_q  <= cmd_i.lane;
          first_q <= 1'b1;
          if (cmd_i.len != '0)       st_q <= ST_SEND;
          else if (cmd_i.lane != '0) st_q <= ST_SKIP;
        end
        ST_SEND: if (hs) begin
          first_q <= 1'b0;
          rem_q   <= rem_q - 1'b1;
          lane_q  <= lane_q + 1'b1;
          if (last_byte) st_q <= ST_IDLE;
        end
        ST_SKIP: if (!dat_empty_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_irq_ctrl.sv
module tx_irq_ctrl
  import tx_pkt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] set_i,
  input  logic             rd_i,
  input  logic [SRC_N-1:0] en_i,
  output logic [SRC_N-1:0] src_o,
  output logic             irq_o
);
  logic [SRC_N-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= (rd_i ? '0 : src_q) | set_i;
  end

  assign src_o = src_q;
  assign irq_o = |(src_q & en_i);
endmodule

// File: rtl/tx_pkt_fifo.sv
module tx_pkt_fifo
  import tx_pkt_pkg::*;
#(
  parameter int DATA_DEPTH = 512,
  parameter int CMD_DEPTH  = 16,
  localparam int CNT_W  = $clog2(DATA_DEPTH + 1),
  localparam int CCNT_W = $clog2(CMD_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              data_push_i,
  input  logic [WORD_W-1:0] data_word_i,
  input  logic              cmd_push_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [CNT_W-1:0]  wcnt_o,
  input  logic [CNT_W-1:0]  ae_thresh_i,
  input  logic [SRC_N-1:0]  irq_en_i,
  input  logic              src_rd_i,
  output logic [SRC_N-1:0]  irq_src_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o,
  input  logic              tx_ready_i
);
  logic              d_empty, d_full, d_pop;
  logic [WORD_W-1:0] d_head;
  logic              c_empty, c_full, c_pop;
  logic [CMD_W-1:0]  c_head;
  logic [CCNT_W-1:0] c_cnt;
  logic [SRC_N-1:0]  src_set;

  tx_sfifo #(.WIDTH(WORD_W), .DEPTH(DATA_DEPTH)) i_dat_fifo (
    .clk_i, .rst_ni, .clr_i(flush_i),
    .push_i(data_push_i), .data_i(data_word_i),
    .pop_i(d_pop), .data_o(d_head),
    .empty_o(d_empty), .full_o(d_full), .count_o(wcnt_o)
  );

  tx_sfifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) i_cmd_fifo (
    .clk_i, .rst_ni, .clr_i(flush_i),
    .push_i(cmd_push_i), .data_i(cmd_i),
    .pop_i(c_pop), .data_o(c_head),
    .empty_o(c_empty), .full_o(c_full), .count_o(c_cnt)
  );

  tx_drain i_drain (
    .clk_i, .rst_ni, .flush_i,
    .cmd_empty_i(c_empty), .cmd_i(tx_cmd_t'(c_head)), .cmd_pop_o(c_pop),
    .dat_empty_i(d_empty), .dat_i(d_head), .dat_pop_o(d_pop),
    .tx_valid_o, .tx_data_o, .tx_sof_o, .tx_eof_o, .tx_ready_i
  );

  always_comb begin
    src_set           = '0;
    src_set[SRC_AE]   = (wcnt_o < ae_thresh_i);
    src_set[SRC_FULL] = d_full;
    src_set[SRC_DISC] = cmd_push_i && c_full && !flush_i;
  end

  tx_irq_ctrl i_irq (
    .clk_i, .rst_ni, .set_i(src_set), .rd_i(src_rd_i),
    .en_i(irq_en_i), .src_o(irq_src_o), .irq_o
  );

  logic unused_c_cnt;
  assign unused_c_cnt = ^c_cnt;
endmodule

// File: rtl/tx_pkt_fifo_chk.sv
module tx_pkt_fifo_chk #(
  parameter int DATA_DEPTH = 512,
  localparam int CNT_W = $clog2(DATA_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             cmd_push_i,
  input logic             cmd_full_i,
  input logic [CNT_W-1:0] wcnt_o,
  input logic [2:0]       irq_src_o,
  input logic             tx_valid_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_sof_o,
  input logic             tx_eof_o,
  input logic             tx_ready_i
);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_o <= CNT_W'(DATA_DEPTH));

  a_r3_marks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sof_o || tx_eof_o) |-> tx_valid_o);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !flush_i) |=>
      (tx_valid_o && $stable(tx_data_o) && $stable(tx_sof_o) && $stable(tx_eof_o)));

  a_r8_full_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcnt_o == CNT_W'(DATA_DEPTH)) |=> irq_src_o[1]);

  a_r9_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_push_i && cmd_full_i && !flush_i) |=> irq_src_o[2]);

  a_r10_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (wcnt_o == '0 && !tx_valid_o));
endmodule

bind tx_pkt_fifo tx_pkt_fifo_chk #(.DATA_DEPTH(DATA_DEPTH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
  .cmd_push_i(cmd_push_i), .cmd_full_i(c_full), .wcnt_o(wcnt_o),
  .irq_src_o(irq_src_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
  .tx_sof_o(tx_sof_o), .tx_eof_o(tx_eof_o), .tx_ready_i(tx_ready_i)
);

// File: tb/test_tx_pkt_fifo.sv
`timescale 1ns/1ps
module test_tx_pkt_fifo;
  localparam int DD = 16;
  localparam int CD = 4;
  localparam int CW = $clog2(DD + 1);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic data_push = 1'b0, cmd_push = 1'b0, src_rd = 1'b0, rdy = 1'b0;
  logic [31:0] data_word = '0;
  logic [17:0] cmd = '0;
  logic [CW-1:0] wcnt, thresh = '0;
  logic [2:0] irq_en = '0, src;
  logic irq, tv, sof, eof;
  logic [7:0] td;
  int checks = 0, errors = 0;
  logic [31:0] wbuf [64];

  always #2 clk = ~clk;

  tx_pkt_fifo #(.DATA_DEPTH(DD), .CMD_DEPTH(CD)) i_tx_pkt_fifo (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .data_push_i(data_push), .data_word_i(data_word),
    .cmd_push_i(cmd_push), .cmd_i(cmd), .wcnt_o(wcnt),
    .ae_thresh_i(thresh), .irq_en_i(irq_en), .src_rd_i(src_rd),
    .irq_src_o(src), .irq_o(irq), .tx_valid_o(tv), .tx_data_o(td),
    .tx_sof_o(sof), .tx_eof_o(eof), .tx_ready_i(rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_w(input int idx, input logic [31:0] w);
    wbuf[idx] = w;
    data_push = 1'b1; data_word = w;
    @(negedge clk);
    data_push = 1'b0;
  endtask

  task automatic push_c(input int len, input int lane);
    cmd_push = 1'b1; cmd = {2'(lane), 16'(len)};
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  function automatic int nwords(input int len, input int lane);
    return (len + lane + 3) / 4;
  endfunction

  function automatic logic [7:0] exp_byte(input int base, input int pos);
    logic [31:0] w;
    w = wbuf[base + pos / 4];
    return w[(pos % 4) * 8 +: 8];
  endfunction

  task automatic load(input int base, input int len, input int lane);
    for (int i = 0; i < nwords(len, lane); i++) push_w(base + i, $urandom);
  endtask

  // R3 R4 R6: collect one frame under random backpressure
  task automatic recv(input int base, input int len, input int lane);
    int idx = 0;
    int cyc = 0;
    bit bad = 0;
    logic [7:0] e;
    while (idx < len && cyc < 4000) begin
      rdy = ($urandom % 4) != 0;
      if (tv && rdy) begin
        e = exp_byte(base, lane + idx);
        if (td !== e || sof !== (idx == 0) || eof !== (idx == len - 1)) begin
          bad = 1;
          $display("FAIL R3 byte %0d actual=%0h/%0b/%0b expected=%0h/%0b/%0b",
                   idx, td, sof, eof, e, idx == 0, idx == len - 1);
        end
        idx++;
      end
      cyc++;
      @(negedge clk);
    end
    rdy = 1'b0;
    checks++;
    if (bad) errors++;
    chk(idx == len, "R3 byte count", idx, len);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(!tv && wcnt == 0 && src == 0 && !irq, "R1 reset", {tv, src, irq}, 0);

    // R5: data with no command stays put
    load(0, 10, 2);
    tick(6);
    chk(!tv, "R5 no output without cmd", tv, 0);
    chk(wcnt == 3, "R2 count after pushes", wcnt, 3);
    push_c(10, 2);
    recv(0, 10, 2);
    tick(2);
    chk(wcnt == 0, "R4 words consumed", wcnt, 0);

    // back-to-back frames: R4 boundaries
    load(0, 5, 3);
    load(2, 3, 1);
    push_c(5, 3);
    push_c(3, 1);
    recv(0, 5, 3);
    recv(2, 3, 1);
    tick(2);
    chk(wcnt == 0, "R4 two frames consumed", wcnt, 0);

    // random frames
    for (int f = 0; f < 40; f++) begin
      int lane = $urandom % 4;
      int len = 1 + $urandom % (60 - lane);
      load(0, len, lane);
      chk(wcnt == CW'(nwords(len, lane)), "R2 count before frame", wcnt, nwords(len, lane));
      push_c(len, lane);
      recv(0, len, lane);
      tick(2);
      chk(wcnt == 0, "R4 frame consumed", wcnt, 0);
    end

    // R12 zero-length commands
    push_w(0, 32'hdeadbeef);
    push_c(0, 3);
    tick(4);
    chk(wcnt == 0 && !tv, "R12 zero len lane3 eats one word", wcnt, 0);
    push_w(0, 32'h11223344);
    push_c(0, 0);
    tick(4);
    chk(wcnt == 1 && !tv, "R12 zero len lane0 eats none", wcnt, 1);
    push_c(4, 0);
    recv(0, 4, 0);

    // R8 full and overflow drop
    tick(2);
    for (int i = 0; i < DD; i++) push_w(i, $urandom);
    tick(1);
    chk(wcnt == DD && src[1], "R8 full flag", {wcnt, src}, DD);
    push_w(DD, 32'hcafef00d);
    tick(1);
    chk(wcnt == DD, "R8 overflow dropped", wcnt, DD);

    // R10 flush
    flush = 1'b1; tick(1); flush = 1'b0;
    chk(wcnt == 0 && !tv, "R10 flush empties", wcnt, 0);
    push_w(0, 32'ha1b2c3d4);
    push_c(4, 0);
    recv(0, 4, 0);

    // R9 discard: stall drain with a command lacking data
    push_c(8, 0);
    tick(2);
    src_rd = 1'b1; tick(1); src_rd = 1'b0;
    for (int i = 0; i < CD; i++) push_c(4, 0);
    tick(1);
    chk(!src[2], "R9 no discard below depth", src[2], 0);
    push_c(4, 0);
    tick(1);
    chk(src[2] == 1'b1, "R9 discard set", src[2], 1);

    // R11 masking and read clear
    irq_en = 3'b100;
    tick(1);
    chk(irq, "R11 irq from enabled source", irq, 1);
    irq_en = 3'b001;
    tick(1);
    chk(!irq, "R11 masked source", irq, 0);
    irq_en = 3'b100;
    src_rd = 1'b1; tick(1); src_rd = 1'b0;
    chk(src == 0 && !irq, "R11 read clears", src, 0);

    // R10 flush aborts stalled frame, then R7 threshold
    flush = 1'b1; tick(1); flush = 1'b0;
    push_w(0, 32'h01020304);
    push_c(4, 0);
    recv(0, 4, 0);
    thresh = CW'(4);
    tick(2);
    chk(src[0], "R7 below threshold", src[0], 1);
    for (int i = 0; i < 5; i++) push_w(i, $urandom);
    src_rd = 1'b1; tick(1); src_rd = 1'b0;
    tick(2);
    chk(!src[0], "R7 above threshold stays clear", src[0], 0);
    flush = 1'b1; tick(1); flush = 1'b0;
    tick(2);
    chk(src[0], "R7 set again after drain", src[0], 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule